// File: doc/BRIEF.md
# Serial Port Interrupt Pending and Mask Unit

This block gathers the interrupt events of one serial port and turns them into a single interrupt request for the upstream controller. The port has four event sources. Each source has a sticky latch that is set by a one-cycle pulse on its event input and stays set until software clears it. A per-source mask decides whether a latched event counts toward the interrupt request.

Software reaches the block over a small synchronous register bus with three 32-bit words. The raw word shows every latched event whether or not it is masked. The pending word shows only the latched events whose mask bit is clear. Writing ones to the pending word clears those sources. The mask word holds one enable-inhibit bit per source. The interrupt request is high while any pending bit is set. Software reads the pending word once and services the set bits from bit 0 upward.

Top module: `uart_irq_agg`

## Requirements
- R1: After reset the mask word reads 0x0000000F, the raw and pending words read 0, and `irq_out` is low.
- R2: A one-cycle pulse on `src_evt[n]` sets raw bit n, and the raw word (offset 0x34) shows it from the cycle after the sampling edge, whatever the mask holds.
- R3: The pending word (offset 0x30) reads raw AND NOT mask in bits 3:0, and bits 31:4 of every word read as zero.
- R4: A write to the mask word (offset 0x38) stores `bus_wdata[3:0]`, and the stored value reads back. A one in bit n masks source n and a zero lets it through, so writing 0xF masks all four sources.
- R5: A write to offset 0x30 clears each source whose data bit is one and leaves sources with a zero data bit unchanged.
- R6: A clear through offset 0x30 also drops the raw view, so raw and pending bits fall on the same edge.
- R7: If an event on source n arrives on the same edge as a clear of bit n, bit n stays set.
- R8: `irq_out` is the OR of the four pending bits. It rises in the cycle after an unmasked event is sampled and falls in the cycle after the last pending bit is cleared or masked.
- R9: Writes to offset 0x34 or to any undecoded offset change no state, and undecoded offsets read zero.
- R10: A latched source that is masked keeps its raw bit. Clearing its mask bit makes it pending again and raises `irq_out` with no new event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt | input | 4 | One-cycle event pulses, one per source |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_addr | input | 8 | Byte offset of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Interrupt request to the parent controller |

## Verification
A latch stuck set or lost appears in the raw word in the cycle after the event edge. Through the pending word and `irq_out` it appears only when the source is unmasked. For that reason the bench reads both views after each step and toggles the mask over held latches. A corrupted mask bit makes the pending word and `irq_out` differ from the model on the next read. A wrong priority between clear and event appears only when both land on the same edge, so that collision is driven on purpose and also occurs during the random sequence.

// File: rtl/uart_irq_pkg.sv
`timescale 1ns/1ps
package uart_irq_pkg;
    localparam int unsigned NUM_SRC = 4;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    typedef struct packed {
        src_vec_t raw;
        src_vec_t mask;
    } irq_state_t;
endpackage

// File: rtl/uart_irq_core.sv
`timescale 1ns/1ps
module uart_irq_core
    import uart_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t evt,
    input  src_vec_t clr,
    input  logic     mask_we,
    input  src_vec_t mask_wdata,
    output src_vec_t raw,
    output src_vec_t mask,
    output src_vec_t pend,
    output logic     irq
);
    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_SRC; i++) begin
            // event wins over a simultaneous clear
            st_d.raw[i] = evt[i] | (st_q.raw[i] & ~clr[i]);
        end
        if (mask_we) begin
            st_d.mask = mask_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.raw  <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw  = st_q.raw;
    assign mask = st_q.mask;
    assign pend = st_q.raw & ~st_q.mask;
    assign irq  = |pend;

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
            p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
                evt[g] |=> raw[g]);
            p_clr_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (clr[g] && !evt[g]) |=> !raw[g]);
            p_evt_beats_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (clr[g] && evt[g]) |=> raw[g]);
            p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
                (!clr[g] && !evt[g]) |=> $stable(raw[g]));
        end
    endgenerate

    p_mask_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (mask == $past(mask_wdata)));
    p_mask_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we |=> $stable(mask));
endmodule

// File: rtl/uart_irq_rdmux.sv
`timescale 1ns/1ps
module uart_irq_rdmux
    import uart_irq_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned PEND_OFS = 'h30,
    parameter int unsigned RAW_OFS  = 'h34,
    parameter int unsigned MASK_OFS = 'h38
) (
    input  logic [ADDR_W-1:0] addr,
    input  src_vec_t          raw,
    input  src_vec_t          mask,
    input  src_vec_t          pend,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned PAD_W = DATA_W - NUM_SRC;

    src_vec_t sel_d;

    always_comb begin
        if (addr == ADDR_W'(PEND_OFS)) begin
            sel_d = pend;
        end else if (addr == ADDR_W'(RAW_OFS)) begin
            sel_d = raw;
        end else if (addr == ADDR_W'(MASK_OFS)) begin
            sel_d = mask;
        end else begin
            sel_d = '0;
        end
    end

    assign rdata = {{PAD_W{1'b0}}, sel_d};
endmodule

// File: rtl/uart_irq_agg.sv
`timescale 1ns/1ps
module uart_irq_agg
    import uart_irq_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned PEND_OFS = 'h30,
    parameter int unsigned RAW_OFS  = 'h34,
    parameter int unsigned MASK_OFS = 'h38
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        src_evt,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);
    src_vec_t clr_d, raw_q, mask_q, pend_q;
    logic     mask_we_d;
    logic     wr_pend_d;
    logic     unused_hi;

    assign unused_hi = ^bus_wdata[DATA_W-1:NUM_SRC];

    always_comb begin
        wr_pend_d = bus_wr && (bus_addr == ADDR_W'(PEND_OFS));
        mask_we_d = bus_wr && (bus_addr == ADDR_W'(MASK_OFS));
        clr_d     = wr_pend_d ? bus_wdata[NUM_SRC-1:0] : '0;
    end

    uart_irq_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (src_evt),
        .clr        (clr_d),
        .mask_we    (mask_we_d),
        .mask_wdata (bus_wdata[NUM_SRC-1:0]),
        .raw        (raw_q),
        .mask       (mask_q),
        .pend       (pend_q),
        .irq        (irq_out)
    );

    uart_irq_rdmux #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .PEND_OFS (PEND_OFS),
        .RAW_OFS  (RAW_OFS),
        .MASK_OFS (MASK_OFS)
    ) u_rdmux (
        .addr  (bus_addr),
        .raw   (raw_q),
        .mask  (mask_q),
        .pend  (pend_q),
        .rdata (bus_rdata)
    );

    p_all_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_q) |-> !irq_out);
    p_unmasked_raw_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|(raw_q & ~mask_q)) |-> irq_out);
    p_no_pend_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_pend_d && src_evt == '0) |=> $stable(raw_q));
endmodule

// File: tb/uart_irq_agg_test.sv
`timescale 1ns/1ps
module uart_irq_agg_test;
    localparam logic [7:0] A_PEND = 8'h30;
    localparam logic [7:0] A_RAW  = 8'h34;
    localparam logic [7:0] A_MASK = 8'h38;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src_evt = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int checks = 0;
    int fails  = 0;
    logic [3:0] m_raw = '0;
    logic [3:0] m_mask = 4'hF;
    bit done = 0;

    always #2.5 clk = ~clk;

    uart_irq_agg uut (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // one clock step: drive at a falling edge, sampled at the next rising edge
    task automatic step(logic [3:0] evt, logic wr, logic [7:0] addr, logic [31:0] wd);
        @(negedge clk);
        src_evt = evt; bus_wr = wr; bus_addr = addr; bus_wdata = wd;
        @(negedge clk);
        src_evt = '0; bus_wr = 1'b0;
        if (wr && addr == A_PEND) m_raw = (m_raw & ~wd[3:0]) | evt;
        else                      m_raw = m_raw | evt;
        if (wr && addr == A_MASK) m_mask = wd[3:0];
    endtask

    task automatic rd(logic [7:0] addr, output logic [31:0] v);
        bus_addr = addr;
        #1 v = bus_rdata;
    endtask

    task automatic check_all(string req);
        logic [31:0] v;
        rd(A_RAW, v);  check({req, " raw"}, v, {28'd0, m_raw});
        rd(A_PEND, v); check({req, " pend"}, v, {28'd0, m_raw & ~m_mask});
        rd(A_MASK, v); check({req, " mask"}, v, {28'd0, m_mask});
        check({req, " irq"}, {31'd0, irq_out}, {31'd0, |(m_raw & ~m_mask)});
    endtask

    task automatic t_reset;
        check_all("R1");
    endtask

    task automatic t_event_raw;
        step(4'b0101, 0, A_PEND, 0);
        check_all("R2");
        check("R8 masked no irq", {31'd0, irq_out}, 32'd0);
    endtask

    task automatic t_mask_rw;
        logic [31:0] v;
        step(0, 1, A_MASK, 32'hFFFF_FFFA);
        check_all("R4");
        rd(A_PEND, v); check("R3 pend view", v, 32'h0000_0005);
        check("R8 irq high", {31'd0, irq_out}, 32'd1);
        step(0, 1, A_MASK, 32'h0000_000F);
        check_all("R4 all masked");
    endtask

    task automatic t_w1c;
        step(0, 1, A_MASK, 0);
        step(4'b1010, 0, A_PEND, 0);
        step(0, 1, A_PEND, 32'h0000_0003);
        check_all("R5");
        check_all("R6");
        step(0, 1, A_PEND, 32'hFFFF_FFFF);
        check_all("R8 drop");
        check("R8 irq low", {31'd0, irq_out}, 32'd0);
    endtask

    task automatic t_collision;
        step(4'b0001, 0, A_PEND, 0);
        step(4'b0001, 1, A_PEND, 32'h1);
        check_all("R7");
        check("R7 bit kept", {31'd0, m_raw[0]}, 32'd1);
        step(0, 1, A_PEND, 32'h1);
    endtask

    task automatic t_readonly;
        logic [31:0] v;
        step(4'b0110, 0, A_PEND, 0);
        step(0, 1, A_RAW, 32'hF);
        check_all("R9 raw write");
        step(0, 1, 8'h3C, 32'hF);
        check_all("R9 stray write");
        rd(8'h3C, v); check("R9 stray read", v, 32'd0);
        step(0, 1, A_PEND, 32'hF);
    endtask

    task automatic t_unmask_reveal;
        step(0, 1, A_MASK, 32'hF);
        step(4'b1000, 0, A_PEND, 0);
        check_all("R10 held");
        step(0, 1, A_MASK, 32'h7);
        check_all("R10 reveal");
        check("R10 irq", {31'd0, irq_out}, 32'd1);
        step(0, 1, A_PEND, 32'h8);
    endtask

    task automatic t_random;
        for (int i = 0; i < 300; i++) begin
            logic [3:0] e;
            logic [1:0] k;
            e = 4'($urandom);
            k = 2'($urandom);
            case (k)
                2'd0: step(e, 1, A_PEND, 32'($urandom));
                2'd1: step(e, 1, A_MASK, 32'($urandom));
                default: step(e, 0, A_PEND, 0);
            endcase
            check_all("R8 random");
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_event_raw();
        t_mask_rw();
        t_w1c();
        t_collision();
        t_readonly();
        t_unmask_reveal();
        t_random();
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule